// File: doc/BRIEF.md
# Sticky Interrupt Aggregation Controller

This block gathers 24 peripheral interrupt lines into one request for a parent processor. The block first synchronises every line with two flops. A per-source detector then turns the line into a capture event. The detector is programmable: it can follow the level, the rising edge, the falling edge or both edges. Each capture event sets a sticky pending bit. The bit stays set until software clears it by writing a one to it. The pending bits are masked with a per-source enable. If any masked result is set, the block raises one registered output line.

Software drives a simple register port. An access takes one cycle and has an address, a write strobe and write data. Read data comes back combinationally in the same cycle. The enable register can be written as a whole. It can also be changed bit by bit through a set alias and a clear alias, so no read-modify-write is needed. A destination-0 identity register shows which sources are both pending and enabled. The usual handler sequence is: read the identity register, service the sources it lists, then clear their pending bits. A level source keeps setting its pending bit while its line is high, so a clear only holds once the peripheral has dropped the line.

Top module: `irq_sticky_agg`

## Requirements
- R1: After reset, the enable register, the pending register and both trigger-mode registers read 0, and `irq_o` is low.
- R2: Mode 00 (level) sets the pending bit in the third clock edge after the line rises, and keeps setting it while the line is high. A clear written while the line is still high has no effect. A clear written after the line has dropped for three edges leaves the bit at 0.
- R3: Mode 10 (rising edge) sets the pending bit once for each rising transition. Holding the line high after a clear does not set the bit again, and a falling transition does not set it.
- R4: Mode 11 (falling edge) sets the pending bit only on a high-to-low transition, three edges after the line falls.
- R5: Mode 01 (both edges) sets the pending bit on every rising and every falling transition.
- R6: At offset 0x10, the pending register reads back the pending bits. Writing it clears each bit written as 1 and leaves each bit written as 0 unchanged; 0xFFFFFFFF clears all. If a capture and a clear hit the same bit in the same cycle, the capture wins. No pending bit falls without a write to 0x10.
- R7: At offset 0x18, the enable register is read and written directly. Bits 31:24 of every read return 0.
- R8: A write to 0x1C clears each enable bit written as 1. A write to 0x20 sets each enable bit written as 1. Bits written as 0 are untouched. Both aliases read 0, and enable changes only through 0x18, 0x1C and 0x20.
- R9: Offset 0x38 reads the pending bits ANDed with the enable bits. Offset 0x3C and every other undefined offset read 0, and writes to them change nothing.
- R10: `irq_o` is the OR of the destination-0 identity bits, registered for one cycle.
- R11: Offset 0x5C holds the low trigger-mode bit and offset 0x60 holds the high trigger-mode bit of each source. Both read back as written. Each source's mode is {bit at 0x60, bit at 0x5C}.
- R12: A source whose enable bit is 0 still sets its pending bit, but it does not appear at 0x38 and does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 24 | Peripheral interrupt lines, asynchronous |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe, one access per cycle |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, same cycle |
| irq_o | output | 1 | Interrupt request to the parent processor |

## Verification
A wrong pending or enable bit shows up at once on a read of 0x10, 0x18 or 0x38. It also shows on `irq_o` one edge after the bad state appears. A wrong mode decode or a wrong detector stage shows as a pending bit that is missing, extra or late. The bench samples that bit exactly three edges after the input changes, so a latency error of even one cycle is reported. Clear races are checked by clearing a level source while its line is still high, where the capture must win.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int SRC_N  = 24;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam int OFS_PEND  = 'h10;
    localparam int OFS_MASK  = 'h18;
    localparam int OFS_MCLR  = 'h1C;
    localparam int OFS_MSET  = 'h20;
    localparam int OFS_ID0   = 'h38;
    localparam int OFS_ID1   = 'h3C;
    localparam int OFS_MODE0 = 'h5C;
    localparam int OFS_MODE1 = 'h60;

    typedef enum logic [1:0] {
        TRIG_LEVEL   = 2'b00,
        TRIG_BOTH    = 2'b01,
        TRIG_RISE    = 2'b10,
        TRIG_FALL    = 2'b11
    } trig_e;
endpackage

// File: rtl/irq_sync_2ff.sv
module irq_sync_2ff #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] now_o,
    output logic [N-1:0] prev_o
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = raw_i;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign now_o  = s_q.sync;
    assign prev_o = s_q.prev;
endmodule

// File: rtl/irq_trig_detect.sv
module irq_trig_detect
    import irq_agg_pkg::*;
#(
    parameter int N = 24
) (
    input  logic [N-1:0] now_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] mode0_i,
    input  logic [N-1:0] mode1_i,
    output logic [N-1:0] hit_o
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic  rise_w, fall_w;
        trig_e mode_w;
        assign rise_w = now_i[i] & ~prev_i[i];
        assign fall_w = ~now_i[i] & prev_i[i];
        assign mode_w = trig_e'({mode1_i[i], mode0_i[i]});
        always_comb begin
            case (mode_w)
                TRIG_LEVEL: hit_o[i] = now_i[i];
                TRIG_BOTH:  hit_o[i] = rise_w | fall_w;
                TRIG_RISE:  hit_o[i] = rise_w;
                default:    hit_o[i] = fall_w;
            endcase
        end
    end
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int N  = 24,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [N-1:0]  hit_i,
    output logic [DW-1:0] rdata_o,
    output logic [N-1:0]  en_o,
    output logic [N-1:0]  pend_o,
    output logic [N-1:0]  mode0_o,
    output logic [N-1:0]  mode1_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] pend;
        logic [N-1:0] mode0;
        logic [N-1:0] mode1;
        logic         irq;
    } regs_t;

    regs_t        r_d, r_q;
    logic [N-1:0] wbits;
    logic [N-1:0] clr_w;
    logic [N-1:0] ident_w;
    logic         unused_wdata_hi;

    assign wbits           = wdata_i[N-1:0];
    assign unused_wdata_hi = ^wdata_i[DW-1:N];
    assign ident_w         = r_q.pend & r_q.en;

    always_comb begin
        r_d   = r_q;
        clr_w = '0;
        if (wr_i) begin
            case (addr_i)
                AW'(OFS_PEND):  clr_w     = wbits;
                AW'(OFS_MASK):  r_d.en    = wbits;
                AW'(OFS_MCLR):  r_d.en    = r_q.en & ~wbits;
                AW'(OFS_MSET):  r_d.en    = r_q.en | wbits;
                AW'(OFS_MODE0): r_d.mode0 = wbits;
                AW'(OFS_MODE1): r_d.mode1 = wbits;
                default: ;
            endcase
        end
        // capture beats a same-cycle clear
        r_d.pend = (r_q.pend & ~clr_w) | hit_i;
        r_d.irq  = |ident_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            AW'(OFS_PEND):  rdata_o[N-1:0] = r_q.pend;
            AW'(OFS_MASK):  rdata_o[N-1:0] = r_q.en;
            AW'(OFS_ID0):   rdata_o[N-1:0] = ident_w;
            AW'(OFS_MODE0): rdata_o[N-1:0] = r_q.mode0;
            AW'(OFS_MODE1): rdata_o[N-1:0] = r_q.mode1;
            default: ;
        endcase
    end

    assign en_o    = r_q.en;
    assign pend_o  = r_q.pend;
    assign mode0_o = r_q.mode0;
    assign mode1_o = r_q.mode1;
    assign irq_o   = r_q.irq;
endmodule

// File: rtl/irq_sticky_agg.sv
module irq_sticky_agg
    import irq_agg_pkg::*;
#(
    parameter int N  = SRC_N,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_src_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic          reg_wr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          irq_o
);
    logic [N-1:0] now_w, prev_w, hit_w;
    logic [N-1:0] en_w, pend_w, mode0_w, mode1_w;

    irq_sync_2ff #(.N(N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (irq_src_i),
        .now_o  (now_w),
        .prev_o (prev_w)
    );

    irq_trig_detect #(.N(N)) u_detect (
        .now_i   (now_w),
        .prev_i  (prev_w),
        .mode0_i (mode0_w),
        .mode1_i (mode1_w),
        .hit_o   (hit_w)
    );

    irq_agg_regs #(.N(N), .AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr_i),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .hit_i   (hit_w),
        .rdata_o (reg_rdata_o),
        .en_o    (en_w),
        .pend_o  (pend_w),
        .mode0_o (mode0_w),
        .mode1_o (mode1_w),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/irq_sticky_agg_chk.sv
module irq_sticky_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int N  = SRC_N,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          wr,
    input logic [DW-1:0] rdata,
    input logic [N-1:0]  en_q,
    input logic [N-1:0]  pend_q,
    input logic          irq
);
    // R10
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(pend_q & en_q))));

    // R6
    pend_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == AW'(OFS_PEND)) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R8
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (addr == AW'(OFS_MASK) || addr == AW'(OFS_MCLR) || addr == AW'(OFS_MSET)))
        |=> $stable(en_q));

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:N] == '0);

    // R9
    ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(OFS_ID0)) |-> (rdata[N-1:0] == (pend_q & en_q)));

    // R9
    dest1_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(OFS_ID1)) |-> (rdata == '0));
endmodule

bind irq_sticky_agg irq_sticky_agg_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (reg_addr_i),
    .wr     (reg_wr_i),
    .rdata  (reg_rdata_o),
    .en_q   (en_w),
    .pend_q (pend_w),
    .irq    (irq_o)
);

// File: tb/irq_sticky_agg_tb.sv
module irq_sticky_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] src = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_sticky_agg u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_src_i   (src),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd_reg(8'h10, v); check("R1 pend", v, 32'h0);
        rd_reg(8'h18, v); check("R1 en", v, 32'h0);
        rd_reg(8'h5C, v); check("R1 mode0", v, 32'h0);
        rd_reg(8'h60, v); check("R1 mode1", v, 32'h0);
        rd_reg(8'h38, v); check("R1 ident", v, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr_reg(8'h18, 32'hFFFF_FFFF);
        rd_reg(8'h18, v); check("R7 en full", v, 32'h00FF_FFFF);
        wr_reg(8'h1C, 32'h0000_000F);
        rd_reg(8'h18, v); check("R8 clr alias", v, 32'h00FF_FFF0);
        wr_reg(8'h20, 32'h0000_0003);
        rd_reg(8'h18, v); check("R8 set alias", v, 32'h00FF_FFF3);
        rd_reg(8'h1C, v); check("R8 clr alias reads 0", v, 32'h0);
        rd_reg(8'h20, v); check("R8 set alias reads 0", v, 32'h0);
        wr_reg(8'h18, 32'h0);
        rd_reg(8'h18, v); check("R7 en zero", v, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr_reg(8'h18, 32'h1);
        @(negedge clk); src[0] = 1'b1;
        wait_n(3);
        check("R10 irq not yet", {31'b0, irq}, 32'h0);
        rd_reg(8'h10, v); check("R2 level set", v, 32'h1);
        check("R10 irq one cycle later", {31'b0, irq}, 32'h1);
        wr_reg(8'h10, 32'h1);
        rd_reg(8'h10, v); check("R2 clear while high", v, 32'h1);
        @(negedge clk); src[0] = 1'b0;
        wait_n(3);
        wr_reg(8'h10, 32'h1);
        rd_reg(8'h10, v); check("R2 clear after drop", v, 32'h0);
        check("R10 irq low", {31'b0, irq}, 32'h0);
        wr_reg(8'h18, 32'h0);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr_reg(8'h60, 32'h2);
        @(negedge clk); src[1] = 1'b1;
        wait_n(3);
        rd_reg(8'h10, v); check("R3 rise set", v, 32'h2);
        wr_reg(8'h10, 32'h2);
        wait_n(3);
        rd_reg(8'h10, v); check("R3 no reset while high", v, 32'h0);
        @(negedge clk); src[1] = 1'b0;
        wait_n(4);
        rd_reg(8'h10, v); check("R3 fall ignored", v, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        wr_reg(8'h60, 32'h6);
        wr_reg(8'h5C, 32'h4);
        @(negedge clk); src[2] = 1'b1;
        wait_n(4);
        rd_reg(8'h10, v); check("R4 rise ignored", v, 32'h0);
        @(negedge clk); src[2] = 1'b0;
        wait_n(3);
        rd_reg(8'h10, v); check("R4 fall set", v, 32'h4);
        wr_reg(8'h10, 32'h4);
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr_reg(8'h5C, 32'hC);
        rd_reg(8'h5C, v); check("R11 mode0 readback", v, 32'hC);
        rd_reg(8'h60, v); check("R11 mode1 readback", v, 32'h6);
        @(negedge clk); src[3] = 1'b1;
        wait_n(3);
        rd_reg(8'h10, v); check("R5 rise set", v, 32'h8);
        wr_reg(8'h10, 32'h8);
        rd_reg(8'h10, v); check("R5 cleared", v, 32'h0);
        @(negedge clk); src[3] = 1'b0;
        wait_n(3);
        rd_reg(8'h10, v); check("R5 fall set", v, 32'h8);
    endtask

    task automatic t_ident();
        logic [31:0] v;
        wr_reg(8'h10, 32'hFFFF_FFFF);
        rd_reg(8'h10, v); check("R6 clear all", v, 32'h0);
        @(negedge clk); src[5] = 1'b1;
        wait_n(3);
        @(negedge clk); src[5] = 1'b0;
        wait_n(3);
        rd_reg(8'h10, v); check("R12 masked still pending", v, 32'h20);
        rd_reg(8'h38, v); check("R12 masked not in ident", v, 32'h0);
        check("R12 masked no irq", {31'b0, irq}, 32'h0);
        wr_reg(8'h20, 32'h20);
        rd_reg(8'h38, v); check("R9 ident", v, 32'h20);
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        wr_reg(8'h3C, 32'hFFFF_FFFF);
        wr_reg(8'h40, 32'hFFFF_FFFF);
        rd_reg(8'h3C, v); check("R9 dest1 reads 0", v, 32'h0);
        rd_reg(8'h40, v); check("R9 undefined reads 0", v, 32'h0);
        rd_reg(8'h18, v); check("R9 writes ignored en", v, 32'h20);
        rd_reg(8'h10, v); check("R9 writes ignored pend", v, 32'h20);
        wr_reg(8'h10, 32'h0);
        rd_reg(8'h10, v); check("R6 zero write keeps", v, 32'h20);
        wr_reg(8'h10, 32'h20);
        rd_reg(8'h10, v); check("R6 one write clears", v, 32'h0);
        check("R10 irq dropped", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_enable();
        t_level();
        t_rise();
        t_fall();
        t_both();
        t_ident();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule